// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block paces the instruction cycle of a small bus-based 16-bit processor. A state counter moves through up to sixteen micro-states for each instruction. The first two states are hardwired and do not depend on the opcode. The first copies the program counter into the memory address register. The second reads memory into the instruction register and advances the program counter. The remaining states are execution steps. In those steps a control store, addressed by the opcode and the state index, supplies a 32-bit control word to the datapath. Each bit of that word drives one datapath control line.

An instruction ends after sixteen states, or sooner when the active control word carries its done bit or when the datapath raises an early-done strobe. Either way the counter returns to the fetch state. A halt input freezes the sequencer with an all-zero control word until the next reset. The control store holds a small sample microcode: one short instruction, one instruction that uses all sixteen states, and a default that ends in its first execution step.

Top module: `ucs_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state index is 0 (fetch). Reset also clears any latched halt.
- R2: In state index 0, `ctrl_word` is 0x00000003 for every opcode. Bit 0 drives the program counter onto the bus and bit 1 loads the address register.
- R3: In state index 1, `ctrl_word` is 0x0000001C for every opcode. Bit 2 reads memory, bit 3 loads the instruction register and bit 4 increments the program counter.
- R4: In state indices 2 to 15, `ctrl_word` is the control-store entry for the current `ir_opcode` and state index, and it changes in the same cycle as either of them.
- R5: With no halt and no end condition, the state index rises by one at each clock edge.
- R6: From state index 15 the next state index is 0, even when no done bit is set.
- R7: When the control word in an execution state has bit 31 (done) set, the next state index is 0.
- R8: `done_strobe` high in an execution state makes the next state index 0. In state indices 0 and 1 it has no effect.
- R9: While `halt` is high, and from then on until reset, the state index does not change and `ctrl_word` is 0. The zero word appears in the same cycle that `halt` rises.
- R10: Sample microcode. Opcode 0x01 at index 2 gives 0x800000A0 (bit 5 loads A, bit 7 drives the ALU result, plus done). Opcode 0x02 gives 0x00000180 (bits 7 and 8, output load) at indices 2 to 14 and 0x00000040 (bit 6, B load) at index 15. Any other opcode at index 2 gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freeze request, latched until reset |
| ir_opcode | input | 8 | Current instruction register opcode |
| done_strobe | input | 1 | Early end of the current instruction |
| state_idx | output | 4 | Current micro-state, value k-1 for state k |
| ctrl_word | output | 32 | Datapath control lines for the current state |

## Verification
Two end conditions can meet in one cycle. In state index 15 a wrap is due anyway, and the early-done strobe or a done bit can also be present. The bench raises the strobe in a mid-sequence execution state of the long opcode and in both hardwired states, and expects a return to fetch only in the first case. It also runs the long opcode through index 15 with no strobe and expects the next index to be 0. A halt raised in mid-instruction competes with normal stepping. The bench judges this by a zero word in the same cycle and an index that stays put after the halt is released.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  // control word bit positions
  localparam int CB_PC_OE   = 0;
  localparam int CB_MAR_LD  = 1;
  localparam int CB_MEM_OE  = 2;
  localparam int CB_IR_LD   = 3;
  localparam int CB_PC_INC  = 4;
  localparam int CB_A_LD    = 5;
  localparam int CB_B_LD    = 6;
  localparam int CB_ALU_OE  = 7;
  localparam int CB_OUT_LD  = 8;
  localparam int CB_DONE    = 31;

  // sample opcodes
  localparam logic [7:0] OP_SHORT = 8'h01;
  localparam logic [7:0] OP_LONG  = 8'h02;
endpackage

// File: rtl/ucs_state_ctr.sv
module ucs_state_ctr #(
  parameter int NUM_STATES = 16,
  localparam int ST_W = $clog2(NUM_STATES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            finish,
  output logic [ST_W-1:0] state_q
);
  localparam logic [ST_W-1:0] LAST = ST_W'(NUM_STATES - 1);

  always_ff @(posedge clk) begin
    if (rst)                         state_q <= '0;
    else if (hold)                   state_q <= state_q;
    else if (finish || state_q == LAST) state_q <= '0;
    else                             state_q <= state_q + 1'b1;
  end

  assert_reset_fetch_R1: assert property (@(posedge clk)
    $past(rst) |-> state_q == '0);

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!hold && !finish && state_q != LAST) |=> state_q == ST_W'($past(state_q) + 1'b1));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!hold && state_q == LAST) |=> state_q == '0);

  assert_end_early_R7: assert property (@(posedge clk) disable iff (rst)
    (!hold && finish) |=> state_q == '0);

  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(state_q));
endmodule

// File: rtl/ucs_ctrl_store.sv
module ucs_ctrl_store
  import ucs_pkg::*;
#(
  parameter int OPC_W      = 8,
  parameter int NUM_STATES = 16,
  parameter int CW_W       = 32,
  localparam int ST_W = $clog2(NUM_STATES)
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [ST_W-1:0]  state_idx,
  output logic [CW_W-1:0]  exec_word
);
  localparam logic [ST_W-1:0] LAST = ST_W'(NUM_STATES - 1);

  // sample microcode, indexed by opcode and execution state
  function automatic logic [CW_W-1:0] lookup(logic [OPC_W-1:0] opc, logic [ST_W-1:0] idx);
    logic [CW_W-1:0] w;
    w = '0;
    if (opc == OPC_W'(OP_SHORT)) begin
      if (idx == ST_W'(2)) begin
        w[CB_A_LD]   = 1'b1;
        w[CB_ALU_OE] = 1'b1;
        w[CB_DONE]   = 1'b1;
      end
    end else if (opc == OPC_W'(OP_LONG)) begin
      if (idx == LAST) begin
        w[CB_B_LD] = 1'b1;
      end else if (idx >= ST_W'(2)) begin
        w[CB_ALU_OE] = 1'b1;
        w[CB_OUT_LD] = 1'b1;
      end
    end else begin
      if (idx == ST_W'(2)) w[CB_DONE] = 1'b1;
    end
    return w;
  endfunction

  always_comb exec_word = lookup(opcode, state_idx);
endmodule

// File: rtl/ucs_word_sel.sv
module ucs_word_sel
  import ucs_pkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int CW_W       = 32,
  localparam int ST_W = $clog2(NUM_STATES)
) (
  input  logic [ST_W-1:0] state_idx,
  input  logic [CW_W-1:0] exec_word,
  input  logic            frozen,
  output logic [CW_W-1:0] word
);
  always_comb begin
    word = '0;
    if (!frozen) begin
      if (state_idx == ST_W'(0)) begin
        word[CB_PC_OE]  = 1'b1;
        word[CB_MAR_LD] = 1'b1;
      end else if (state_idx == ST_W'(1)) begin
        word[CB_MEM_OE] = 1'b1;
        word[CB_IR_LD]  = 1'b1;
        word[CB_PC_INC] = 1'b1;
      end else begin
        word = exec_word;
      end
    end
  end
endmodule

// File: rtl/ucs_sequencer.sv
module ucs_sequencer
  import ucs_pkg::*;
#(
  parameter int OPC_W      = 8,
  parameter int NUM_STATES = 16,
  parameter int CW_W       = 32,
  localparam int ST_W = $clog2(NUM_STATES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [OPC_W-1:0] ir_opcode,
  input  logic             done_strobe,
  output logic [ST_W-1:0]  state_idx,
  output logic [CW_W-1:0]  ctrl_word
);
  logic            halted_q;
  logic            frozen;
  logic            in_exec;
  logic            finish;
  logic [CW_W-1:0] exec_word;

  always_ff @(posedge clk) begin
    if (rst) halted_q <= 1'b0;
    else     halted_q <= halted_q | halt;
  end

  assign frozen  = halt | halted_q;
  assign in_exec = state_idx >= ST_W'(2);
  assign finish  = in_exec & (exec_word[CB_DONE] | done_strobe);

  ucs_state_ctr #(.NUM_STATES(NUM_STATES)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .hold    (frozen),
    .finish  (finish),
    .state_q (state_idx)
  );

  ucs_ctrl_store #(.OPC_W(OPC_W), .NUM_STATES(NUM_STATES), .CW_W(CW_W)) u_store (
    .opcode    (ir_opcode),
    .state_idx (state_idx),
    .exec_word (exec_word)
  );

  ucs_word_sel #(.NUM_STATES(NUM_STATES), .CW_W(CW_W)) u_sel (
    .state_idx (state_idx),
    .exec_word (exec_word),
    .frozen    (frozen),
    .word      (ctrl_word)
  );

  assert_halt_zero_R9: assert property (@(posedge clk) disable iff (rst)
    halted_q |-> ctrl_word == '0);

  assert_strobe_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!frozen && state_idx == ST_W'(1)) |=> state_idx == ST_W'(2));
endmodule

// File: tb/ucs_sequencer_tb.sv
`timescale 1ns/1ps
module ucs_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic [7:0]  ir_opcode = 8'h00;
  logic        done_strobe = 1'b0;
  logic [3:0]  state_idx;
  logic [31:0] ctrl_word;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [31:0] W_FETCH = 32'h0000_0003;
  localparam logic [31:0] W_DEC   = 32'h0000_001C;

  always #2.5 clk = ~clk;

  ucs_sequencer u_dut (
    .clk (clk), .rst (rst), .halt (halt), .ir_opcode (ir_opcode),
    .done_strobe (done_strobe), .state_idx (state_idx), .ctrl_word (ctrl_word)
  );

  // {opcode, 3'b0, strobe, expected index, expected word}
  localparam int NV = 14;
  localparam logic [47:0] VEC [0:NV-1] = '{
    {8'h01, 4'h0, 4'd0, W_FETCH},       // R2
    {8'h01, 4'h0, 4'd1, W_DEC},         // R3
    {8'h01, 4'h0, 4'd2, 32'h8000_00A0}, // R10 R7
    {8'h07, 4'h0, 4'd0, W_FETCH},
    {8'h07, 4'h0, 4'd1, W_DEC},
    {8'h07, 4'h0, 4'd2, 32'h8000_0000}, // R10
    {8'h02, 4'h0, 4'd0, W_FETCH},
    {8'h02, 4'h1, 4'd1, W_DEC},         // R8 strobe ignored
    {8'h02, 4'h0, 4'd2, 32'h0000_0180}, // R4
    {8'h02, 4'h0, 4'd3, 32'h0000_0180},
    {8'h02, 4'h1, 4'd4, 32'h0000_0180}, // R8 strobe ends
    {8'h00, 4'h1, 4'd0, W_FETCH},       // R8 strobe ignored
    {8'h00, 4'h0, 4'd1, W_DEC},
    {8'h00, 4'h0, 4'd2, 32'h8000_0000}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] long_word(int k);
    if (k == 0) return W_FETCH;
    if (k == 1) return W_DEC;
    if (k == 15) return 32'h0000_0040;
    return 32'h0000_0180;
  endfunction

  initial begin
    #1;
    step();
    step();
    check("R1 reset index", 32'(state_idx), 32'd0);
    check("R1 reset word", ctrl_word, W_FETCH);
    rst = 1'b0;
    #1;

    for (int i = 0; i < NV; i++) begin
      ir_opcode   = VEC[i][47:40];
      done_strobe = VEC[i][36];
      #1;
      check($sformatf("R4 R5 R7 R8 vec%0d index", i), 32'(state_idx), 32'(VEC[i][35:32]));
      check($sformatf("R2 R3 R10 vec%0d word", i), ctrl_word, VEC[i][31:0]);
      step();
    end
    done_strobe = 1'b0;
    check("R7 after done index", 32'(state_idx), 32'd0);

    // full-length instruction and wrap
    ir_opcode = 8'h02;
    for (int k = 0; k < 16; k++) begin
      #1;
      check($sformatf("R5 long index %0d", k), 32'(state_idx), 32'(k));
      check($sformatf("R10 long word %0d", k), ctrl_word, long_word(k));
      step();
    end
    check("R6 wrap index", 32'(state_idx), 32'd0);

    // opcode change reflects in same cycle
    step(); step(); // index 2
    ir_opcode = 8'h01;
    #1;
    check("R4 same-cycle opcode", ctrl_word, 32'h8000_00A0);
    ir_opcode = 8'h02;
    step(); step(); step(); // index 5

    // halt
    halt = 1'b1;
    #1;
    check("R9 zero word same cycle", ctrl_word, 32'h0);
    check("R9 index at halt", 32'(state_idx), 32'd5);
    step(); step(); step();
    halt = 1'b0;
    step(); step();
    check("R9 frozen index", 32'(state_idx), 32'd5);
    check("R9 word stays zero", ctrl_word, 32'h0);

    rst = 1'b1;
    step();
    rst = 1'b0;
    ir_opcode = 8'hFF;
    #1;
    check("R1 halt cleared index", 32'(state_idx), 32'd0);
    check("R1 halt cleared word", ctrl_word, W_FETCH);
    step();
    check("R3 decode any opcode", ctrl_word, W_DEC);
    step();
    check("R10 default opcode", ctrl_word, 32'h8000_0000);
    step();
    check("R7 default ends", 32'(state_idx), 32'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule